// File: doc/BRIEF.md
# Program memory table access unit

This block gives a 16-bit data path byte and word access to a program memory whose words are 24 bits wide. Each stored word is split into a 16-bit low lane and an 8-bit high lane. Above the high lane sits an upper byte that does not exist in storage, so it always reads as zero. A table address is built by placing an 8-bit page register above a 16-bit effective address. Bit 0 of that address selects a byte within a word, because successive program words are two address units apart. The top page bit chooses between the writable user space and a read-only configuration space.

Requests arrive on a valid/ready port and carry an operation code, a byte/word flag, the effective address and write data. A request is accepted on any cycle in which `req_valid` and `req_ready` are both high. Reads return one 16-bit result on a valid/ready response port. The response register holds one entry. While that entry waits with `rsp_ready` low, `req_ready` is low and no request of any kind is taken. Writes merge the selected byte or word into the stored word and produce no response. The page register is loaded through a plain control pair. A one-cycle error pulse flags any write aimed at configuration space. The model holds 256 words per space. User words reset to zero. Configuration words are computed from their index.

Top module: `prog_table_unit`

## Requirements
- R1: The table address is {page, ea}. ea[0] is the byte select, and ea[8:1] is the word index. If page[6:0] or ea[15:9] is non-zero, the access is out of range: a read returns 0x0000 and a write changes nothing.
- R2: Read-low in word mode (op 2'b00, byte flag 0) returns bits 15:0 of the addressed word.
- R3: Read-low in byte mode returns word bits 15:8 when ea[0]=1, or word bits 7:0 when ea[0]=0. The result is placed in data bits 7:0, and data bits 15:8 are zero.
- R4: Read-high in word mode (op 2'b01, byte flag 0) returns word bits 23:16 in data bits 7:0, and data bits 15:8 are always zero.
- R5: Read-high in byte mode returns word bits 23:16 in data bits 7:0 when ea[0]=0, and returns 0x0000 when ea[0]=1.
- R6: Write-low (op 2'b10) in word mode stores wdata[15:0] into word bits 15:0. In byte mode it stores wdata[7:0] into word bits 15:8 when ea[0]=1, or into bits 7:0 when ea[0]=0. No other bits change.
- R7: Write-high (op 2'b11) stores wdata[7:0] into word bits 23:16 in word mode, and in byte mode when ea[0]=0. wdata[15:8] is discarded. A byte-mode write-high with ea[0]=1 targets the phantom byte and changes nothing.
- R8: With page[7]=1, reads come from configuration space. Configuration word i is {i^8'hC3, i, ~i} (bits 23:16, 15:8, 7:0). Writes there leave all memory unchanged, and `cfg_err` is high for exactly the one cycle after the write is accepted. `cfg_err` is low at all other times.
- R9: An accepted read raises `rsp_valid` with its data one cycle later. Writes raise no response. `rsp_valid` and `rsp_data` hold while `rsp_ready` is low. `req_ready` equals `!rsp_valid || rsp_ready`.
- R10: After reset, `rsp_valid`, `cfg_err` and `cfg_space` are 0, the page is 0, and every user word reads 0.
- R11: A cycle with `pg_load` high loads `pg_value` into the page register from the next cycle on. `cfg_space` shows page bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pg_load | input | 1 | Load strobe for the page register |
| pg_value | input | 8 | New page value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_op | input | 2 | 00 read-low, 01 read-high, 10 write-low, 11 write-high |
| req_byte | input | 1 | 1 = byte mode, 0 = word mode |
| req_ea | input | 16 | Effective address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read result valid |
| rsp_ready | input | 1 | Consumer accepts the read result |
| rsp_data | output | 16 | Read result |
| cfg_space | output | 1 | Page selects configuration space |
| cfg_err | output | 1 | One-cycle pulse after a write aimed at configuration space |

## Verification
The bench targets the phantom byte. It reads high in word mode and in byte mode with ea[0]=1, which exposes a design that leaks stored bits into data bits 15:8. It also writes to the phantom byte, which exposes a design that corrupts the high lane. It swaps the byte select on low-lane accesses, catching swapped halves, and it reads from configuration space and out-of-range addresses, where a wrong design would return user data or alias onto low words. Finally it stalls the response port while a second read waits, which reveals a design that drops or overwrites the held result.

// File: rtl/tpu_pkg.sv
package tpu_pkg;
  localparam int WORD_W = 24;
  localparam int DATA_W = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = WORD_W / LANE_W;

  typedef enum logic [1:0] {
    OP_RD_LO = 2'b00,
    OP_RD_HI = 2'b01,
    OP_WR_LO = 2'b10,
    OP_WR_HI = 2'b11
  } tpu_op_e;

  // Fixed pattern used for the read-only configuration space
  function automatic logic [WORD_W-1:0] cfg_word(input logic [7:0] i);
    return {i ^ 8'hC3, i, ~i};
  endfunction
endpackage

// File: rtl/tpu_addr_decode.sv
module tpu_addr_decode #(
  parameter int PAGE_W = 8,
  parameter int EA_W   = 16,
  parameter int IDX_W  = 8
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [EA_W-1:0]   ea,
  output logic [IDX_W-1:0]  idx,
  output logic              bsel,
  output logic              cfg_sel,
  output logic              in_range
);
  localparam int TA_W   = PAGE_W + EA_W;
  localparam int HI_LSB = IDX_W + 1;
  localparam int HI_MSB = TA_W - 2;

  logic [TA_W-1:0] taddr;

  always_comb begin
    taddr    = {page, ea};
    bsel     = taddr[0];
    idx      = taddr[IDX_W:1];
    cfg_sel  = taddr[TA_W-1];
    in_range = (taddr[HI_MSB:HI_LSB] == '0);
  end
endmodule

// File: rtl/tpu_lane_mux.sv
module tpu_lane_mux
  import tpu_pkg::*;
(
  input  tpu_op_e             op,
  input  logic                byte_mode,
  input  logic                bsel,
  input  logic [WORD_W-1:0]   word,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [LANES-1:0]    wr_be,
  output logic [WORD_W-1:0]   wr_word
);
  logic phantom;

  always_comb begin
    phantom = byte_mode && bsel;
    rdata   = '0;
    wr_be   = '0;
    wr_word = '0;
    unique case (op)
      OP_RD_LO: begin
        if (!byte_mode)  rdata = word[15:0];
        else if (bsel)   rdata = {8'h00, word[15:8]};
        else             rdata = {8'h00, word[7:0]};
      end
      OP_RD_HI: begin
        if (!phantom)    rdata = {8'h00, word[23:16]};
      end
      OP_WR_LO: begin
        if (!byte_mode) begin
          wr_be         = 3'b011;
          wr_word[15:0] = wdata;
        end else if (bsel) begin
          wr_be          = 3'b010;
          wr_word[15:8]  = wdata[7:0];
        end else begin
          wr_be          = 3'b001;
          wr_word[7:0]   = wdata[7:0];
        end
      end
      OP_WR_HI: begin
        if (!phantom) begin
          wr_be          = 3'b100;
          wr_word[23:16] = wdata[7:0];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tpu_word_store.sv
module tpu_word_store
  import tpu_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [LANES-1:0]    wr_be,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [WORD_W-1:0]   wr_word,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic                rd_cfg,
  output logic [WORD_W-1:0]   rd_word
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] umem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) umem[i] <= '0;
    end else if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_be[l]) umem[wr_idx][l*LANE_W +: LANE_W] <= wr_word[l*LANE_W +: LANE_W];
      end
    end
  end

  always_comb begin
    if (rd_cfg) rd_word = cfg_word(8'(rd_idx));
    else        rd_word = umem[rd_idx];
  end
endmodule

// File: rtl/prog_table_unit.sv
module prog_table_unit
  import tpu_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int EA_W   = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_load,
  input  logic [PAGE_W-1:0] pg_value,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_byte,
  input  logic [EA_W-1:0]   req_ea,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_data,
  output logic              cfg_space,
  output logic              cfg_err
);
  logic [PAGE_W-1:0] page_q;
  logic [IDX_W-1:0]  idx;
  logic              bsel, cfg_sel, in_range;
  logic              accept, is_wr, wr_en;
  logic [WORD_W-1:0] st_word, word_eff, wr_word;
  logic [LANES-1:0]  wr_be;
  logic [DATA_W-1:0] rd_fmt;
  tpu_op_e           op;

  assign op        = tpu_op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign is_wr     = req_op[1];
  assign wr_en     = accept && is_wr && !cfg_sel && in_range;
  assign word_eff  = in_range ? st_word : '0;
  assign cfg_space = page_q[PAGE_W-1];

  tpu_addr_decode #(.PAGE_W(PAGE_W), .EA_W(EA_W), .IDX_W(IDX_W)) u_dec (
    .page(page_q), .ea(req_ea), .idx(idx), .bsel(bsel),
    .cfg_sel(cfg_sel), .in_range(in_range)
  );

  tpu_lane_mux u_mux (
    .op(op), .byte_mode(req_byte), .bsel(bsel), .word(word_eff),
    .wdata(req_wdata), .rdata(rd_fmt), .wr_be(wr_be), .wr_word(wr_word)
  );

  tpu_word_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_idx(idx),
    .wr_word(wr_word), .rd_idx(idx), .rd_cfg(cfg_sel), .rd_word(st_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      cfg_err   <= 1'b0;
    end else begin
      if (pg_load) page_q <= pg_value;
      cfg_err <= accept && is_wr && cfg_sel;
      if (accept && !is_wr) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_fmt;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tpu_checker.sv
module tpu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_op,
  input logic        req_byte,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_data,
  input logic        cfg_space,
  input logic        cfg_err
);
  logic acc;
  assign acc = req_valid && req_ready;

  AST_READ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_op[1] |=> rsp_valid) else $error("read lost"); // R9
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)) else $error("rsp dropped"); // R9
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready) else $error("accept while stalled"); // R9
  AST_HI_PHANTOM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == 2'b01 |=> rsp_data[15:8] == 8'h00) else $error("phantom leak"); // R4
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_op[1] && req_byte |=> rsp_data[15:8] == 8'h00) else $error("byte upper"); // R3
  AST_CFG_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op[1] && cfg_space |=> cfg_err) else $error("no err"); // R8
  AST_CFG_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && req_op[1] && cfg_space) |=> !cfg_err) else $error("stray err"); // R8
endmodule

bind prog_table_unit tpu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_byte(req_byte), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .cfg_space(cfg_space),
  .cfg_err(cfg_err)
);

// File: tb/test_prog_table_unit.sv
module test_prog_table_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg_load = 1'b0;
  logic [7:0]  pg_value = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic        req_byte = 1'b0;
  logic [15:0] req_ea = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic        cfg_space;
  logic        cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [7:0]  page_m = '0;
  logic [23:0] umodel [256];

  always #2.5 clk = ~clk;

  prog_table_unit i_prog_table_unit (
    .clk(clk), .rst_n(rst_n), .pg_load(pg_load), .pg_value(pg_value),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_byte(req_byte), .req_ea(req_ea), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cfg_space(cfg_space), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] fetch(input logic [7:0] pg, input logic [15:0] ea);
    logic [7:0] i;
    i = ea[8:1];
    if (pg[6:0] != 0 || ea[15:9] != 0) return 24'h0;
    if (pg[7]) return {i ^ 8'hC3, i, ~i};
    return umodel[i];
  endfunction

  function automatic logic [15:0] exp_rd(input logic [1:0] op, input logic byt,
                                         input logic [7:0] pg, input logic [15:0] ea);
    logic [23:0] w;
    w = fetch(pg, ea);
    if (op == 2'b00) begin
      if (!byt) return w[15:0];
      return ea[0] ? {8'h0, w[15:8]} : {8'h0, w[7:0]};
    end
    if (byt && ea[0]) return 16'h0;
    return {8'h0, w[23:16]};
  endfunction

  task automatic model_wr(input logic [1:0] op, input logic byt, input logic [15:0] ea,
                          input logic [15:0] wd);
    logic [7:0] i;
    i = ea[8:1];
    if (page_m != 0 || ea[15:9] != 0) return;
    if (op == 2'b10) begin
      if (!byt) umodel[i][15:0] = wd;
      else if (ea[0]) umodel[i][15:8] = wd[7:0];
      else umodel[i][7:0] = wd[7:0];
    end else if (!(byt && ea[0])) begin
      umodel[i][23:16] = wd[7:0];
    end
  endtask

  task automatic load_page(input logic [7:0] v);
    @(negedge clk);
    pg_load = 1'b1; pg_value = v;
    @(negedge clk);
    pg_load = 1'b0;
    page_m = v;
    chk("R11 cfg_space", {31'b0, cfg_space}, {31'b0, v[7]});
  endtask

  task automatic run_op(input string req, input logic [1:0] op, input logic byt,
                        input logic [15:0] ea, input logic [15:0] wd);
    @(negedge clk);
    req_op = op; req_byte = byt; req_ea = ea; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!op[1]) begin
      chk({req, " rsp_valid R9"}, {31'b0, rsp_valid}, 32'd1);
      chk(req, {16'b0, rsp_data}, {16'b0, exp_rd(op, byt, page_m, ea)});
    end else begin
      chk({req, " no rsp R9"}, {31'b0, rsp_valid}, 32'd0);
      chk({req, " cfg_err R8"}, {31'b0, cfg_err}, {31'b0, page_m[7]});
      model_wr(op, byt, ea, wd);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    for (int i = 0; i < 256; i++) umodel[i] = '0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R10 cfg_err", {31'b0, cfg_err}, 32'd0);
    chk("R10 cfg_space", {31'b0, cfg_space}, 32'd0);
    chk("R9 req_ready idle", {31'b0, req_ready}, 32'd1);
    run_op("R10 zero word", 2'b00, 1'b0, 16'h000A, 16'h0);

    // R6/R7 writes then R2-R5 reads
    run_op("R6 wr lo word", 2'b10, 1'b0, 16'h0010, 16'hBEEF);
    run_op("R7 wr hi word", 2'b11, 1'b0, 16'h0010, 16'hFF5A);
    run_op("R2 rd lo word", 2'b00, 1'b0, 16'h0010, 16'h0);
    run_op("R3 rd lo byte sel1", 2'b00, 1'b1, 16'h0011, 16'h0);
    run_op("R3 rd lo byte sel0", 2'b00, 1'b1, 16'h0010, 16'h0);
    run_op("R4 rd hi word", 2'b01, 1'b0, 16'h0010, 16'h0);
    run_op("R5 rd hi byte sel0", 2'b01, 1'b1, 16'h0010, 16'h0);
    run_op("R5 rd hi byte sel1", 2'b01, 1'b1, 16'h0011, 16'h0);
    run_op("R7 wr phantom", 2'b11, 1'b1, 16'h0011, 16'h0077);
    run_op("R7 phantom ignored", 2'b01, 1'b0, 16'h0010, 16'h0);
    run_op("R6 wr lo byte sel1", 2'b10, 1'b1, 16'h0011, 16'h1234);
    run_op("R6 wr lo byte sel0", 2'b10, 1'b1, 16'h0010, 16'h5678);
    run_op("R6 merged lo", 2'b00, 1'b0, 16'h0010, 16'h0);
    run_op("R7 wr hi byte sel0", 2'b11, 1'b1, 16'h0010, 16'hAA99);
    run_op("R7 merged hi", 2'b01, 1'b0, 16'h0010, 16'h0);

    // R1 out of range
    run_op("R1 wr oor", 2'b10, 1'b0, 16'h0200, 16'hDEAD);
    run_op("R1 alias idx0 unchanged", 2'b00, 1'b0, 16'h0000, 16'h0);
    run_op("R1 rd oor", 2'b00, 1'b0, 16'h0210, 16'h0);
    load_page(8'h01);
    run_op("R1 rd page oor", 2'b00, 1'b0, 16'h0010, 16'h0);

    // R8 configuration space
    load_page(8'h80);
    run_op("R8 cfg rd lo", 2'b00, 1'b0, 16'h0006, 16'h0);
    run_op("R8 cfg rd hi", 2'b01, 1'b0, 16'h0006, 16'h0);
    run_op("R8 cfg wr", 2'b10, 1'b0, 16'h0010, 16'h0);
    @(negedge clk);
    chk("R8 cfg_err one cycle", {31'b0, cfg_err}, 32'd0);
    load_page(8'h00);
    run_op("R8 cfg wr left user", 2'b00, 1'b0, 16'h0010, 16'h0);

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_op = 2'b00; req_byte = 1'b0; req_ea = 16'h0010; req_valid = 1'b1;
    @(negedge clk);
    req_ea = 16'h0000;
    chk("R9 stall valid", {31'b0, rsp_valid}, 32'd1);
    chk("R9 stall ready low", {31'b0, req_ready}, 32'd0);
    held = rsp_data;
    chk("R9 first data", {16'b0, held}, {16'b0, exp_rd(2'b00, 1'b0, 8'h00, 16'h0010)});
    repeat (2) @(negedge clk);
    chk("R9 held data", {16'b0, rsp_data}, {16'b0, held});
    chk("R9 held valid", {31'b0, rsp_valid}, 32'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 second read", {16'b0, rsp_data}, {16'b0, exp_rd(2'b00, 1'b0, 8'h00, 16'h0000)});
    @(negedge clk);
    chk("R9 drained", {31'b0, rsp_valid}, 32'd0);

    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [1:0]  op;
      logic [15:0] ea;
      int sel;
      sel = $urandom_range(0, 19);
      if (sel == 0) load_page(8'h80);
      else if (sel == 1) load_page(8'h00);
      else if (sel == 2) load_page(8'h02);
      op = 2'($urandom_range(0, 3));
      ea = ($urandom_range(0, 9) == 0) ? 16'($urandom) : 16'($urandom_range(0, 16'h01FF));
      run_op("R2-R7 random", op, 1'($urandom_range(0, 1)), ea, 16'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule